// File: doc/BRIEF.md
# Iterative 256-bit Tweakable Block Cipher Encryption Core

This core encrypts one 256-bit block, held as four 64-bit words, under a 256-bit key and a 128-bit tweak. Once a start strobe is accepted it runs one full round per clock. A round adds a subkey to the state on every fourth round, applies two add-rotate-XOR mixers to the two word pairs, and then reorders the words. When the last round is done the final subkey is added and the result is registered, together with a one-cycle done pulse.

The key and tweak are extended when start is accepted: a fifth key word, the XOR of the four key words with a fixed constant, and a third tweak word, t0 XOR t1. These extended words are held in small rotating rings. The rings advance by one position at each injection, so the current subkey always comes from the head of each ring. An optional feed-forward mode XORs the captured plaintext into the output, which gives the chaining-mode compression output directly. Padding, sequencing over several blocks, and decryption are left to the surrounding logic.

Top module: `tf256_core`

## Requirements
- R1: While and just after synchronous active-low reset, `done` is 0 and `result` is all zeros.
- R2: With `feed_fwd` = 0, `result` equals the 72-round encryption of `text_in` under `key_in` and `tweak_in`. Word i of each bus is bits [64i+63:64i], and tweak word 0 is bits [63:0]. Round d adds subkey d/4 when d mod 4 = 0. Subkey s word i is key word (s+i) mod 5, plus tweak word s mod 3 for i=1, plus tweak word (s+1) mod 3 for i=2, plus s for i=3. Key word 4 is 0x1BD11BDAA9FC1A22 XOR the four key words, and tweak word 2 is t0 XOR t1.
- R3: Each round mixes pairs (e0,e1) and (e2,e3) as f0=e0+e1, f1=f0 XOR (e1 rotated left by A), f2=e2+e3, f3=f2 XOR (e3 rotated left by B). (A,B) for round mod 8 = 0..7 is (14,16), (52,57), (23,40), (5,37), (25,33), (46,12), (58,22), (32,32). The next state is (f0,f3,f2,f1). Subkey 18 is added after round 71.
- R4: With `feed_fwd` = 1, each word of `result` is (final state word + final subkey word) XOR the same-index word of `text_in`.
- R5: `done` is high for exactly one cycle. It is set on the 72nd rising edge after the edge that accepts `start`, so the bench sees it on the 73rd falling edge after raising `start`.
- R6: `start` asserted while an encryption is running has no effect on that run's result, its timing, or the number of done pulses.
- R7: `key_in`, `tweak_in`, `text_in` and `feed_fwd` are captured at the accepting edge. Changing them during a run does not alter its result.
- R8: `result` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an encryption when idle |
| feed_fwd | input | 1 | XOR plaintext into the output |
| key_in | input | 256 | Cipher key, four words |
| tweak_in | input | 128 | Tweak, two words |
| text_in | input | 256 | Plaintext block |
| result | output | 256 | Ciphertext or chained output |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a `start` pulse that lands in the middle of a run while every data input has already been changed to different values. Only this shows that the request is dropped and that the operands stay latched. The bench forces it by re-pulsing `start` with fresh random operands partway through a run. It then compares the result with the model output for the original operands and counts the done pulses over a window.

// File: rtl/tfc_pkg.sv
// Package for the tweakable cipher core: word type, parity constant,
// rotation schedule and a rotate helper. Assumes 64-bit words, 4 words/block.
package tfc_pkg;
    localparam int WORD_W  = 64;
    localparam int NWORDS  = 4;
    localparam int BLOCK_W = WORD_W * NWORDS;
    localparam int TWK_W   = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t KEY_PARITY_C = 64'h1BD11BDAA9FC1A22;

    // Rotation amount for the first word pair, indexed by round mod 8.
    function automatic logic [5:0] rot_lo(input logic [2:0] idx);
        case (idx)
            3'd0: return 6'd14;
            3'd1: return 6'd52;
            3'd2: return 6'd23;
            3'd3: return 6'd5;
            3'd4: return 6'd25;
            3'd5: return 6'd46;
            3'd6: return 6'd58;
            default: return 6'd32;
        endcase
    endfunction

    // Rotation amount for the second word pair, indexed by round mod 8.
    function automatic logic [5:0] rot_hi(input logic [2:0] idx);
        case (idx)
            3'd0: return 6'd16;
            3'd1: return 6'd57;
            3'd2: return 6'd40;
            3'd3: return 6'd37;
            3'd4: return 6'd33;
            3'd5: return 6'd12;
            3'd6: return 6'd22;
            default: return 6'd32;
        endcase
    endfunction

    // Left rotation of a word by a variable amount.
    function automatic word_t rotl(input word_t x, input logic [5:0] r);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << r;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction
endpackage

// File: rtl/tfc_key_ring.sv
// Extended key and tweak rings with subkey formation.
// On load it captures the key and tweak and forms the parity key word and
// the third tweak word. On advance both rings rotate one position and the
// injection index increments. Assumes advance never coincides with load.
module tfc_key_ring
    import tfc_pkg::*;
#(
    parameter int NUM_INJ = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               advance,
    input  logic [BLOCK_W-1:0] key_in,
    input  logic [TWK_W-1:0]   tweak_in,
    output logic [BLOCK_W-1:0] subkey
);
    localparam int KRING = NWORDS + 1;
    localparam int TRING = 3;
    localparam int S_W   = $clog2(NUM_INJ + 1);

    word_t          kr [KRING];
    word_t          tr [TRING];
    logic [S_W-1:0] sidx;
    word_t          kpar;

    // Parity word of the incoming key.
    always_comb begin
        kpar = KEY_PARITY_C;
        for (int i = 0; i < NWORDS; i++) kpar ^= key_in[i*WORD_W +: WORD_W];
    end

    // Ring registers: capture on load, rotate on each injection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < KRING - 1; i++) kr[i] <= '0;
            kr[KRING-1] <= KEY_PARITY_C;
            for (int i = 0; i < TRING; i++) tr[i] <= '0;
            sidx <= '0;
        end else if (load) begin
            for (int i = 0; i < NWORDS; i++) kr[i] <= key_in[i*WORD_W +: WORD_W];
            kr[KRING-1] <= kpar;
            tr[0] <= tweak_in[WORD_W-1:0];
            tr[1] <= tweak_in[TWK_W-1:WORD_W];
            tr[2] <= tweak_in[WORD_W-1:0] ^ tweak_in[TWK_W-1:WORD_W];
            sidx  <= '0;
        end else if (advance) begin
            for (int i = 0; i < KRING; i++) kr[i] <= kr[(i + 1) % KRING];
            for (int i = 0; i < TRING; i++) tr[i] <= tr[(i + 1) % TRING];
            sidx <= sidx + 1'b1;
        end
    end

    // Subkey words from the ring heads plus the tweak words and the index.
    always_comb begin
        subkey[0*WORD_W +: WORD_W] = kr[0];
        subkey[1*WORD_W +: WORD_W] = kr[1] + tr[0];
        subkey[2*WORD_W +: WORD_W] = kr[2] + tr[1];
        subkey[3*WORD_W +: WORD_W] = kr[3] + word_t'(sidx);
    end

    // R2: key ring keeps its parity relation through every rotation
    a_r2_key_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (kr[0] ^ kr[1] ^ kr[2] ^ kr[3] ^ kr[4]) == KEY_PARITY_C);
    // R2: the three tweak words always XOR to zero
    a_r2_tweak_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (tr[0] ^ tr[1] ^ tr[2]) == '0);
    // R3: injection index never passes the final subkey
    a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        sidx <= S_W'(NUM_INJ - 1));
endmodule

// File: rtl/tfc_mix.sv
// One add-rotate-XOR mixer on a word pair. Purely combinational.
module tfc_mix
    import tfc_pkg::*;
(
    input  word_t      a,
    input  word_t      b,
    input  logic [5:0] rot,
    output word_t      y0,
    output word_t      y1
);
    // Sum first, then XOR with the rotated second word.
    always_comb begin
        y0 = a + b;
        y1 = y0 ^ rotl(b, rot);
    end
endmodule

// File: rtl/tfc_round.sv
// One full round: optional subkey addition, two mixers, word reorder.
// Combinational; the caller registers the output.
module tfc_round
    import tfc_pkg::*;
(
    input  logic [BLOCK_W-1:0] state_in,
    input  logic [BLOCK_W-1:0] subkey,
    input  logic               inject,
    input  logic [2:0]         rot_idx,
    output logic [BLOCK_W-1:0] state_out
);
    word_t e [NWORDS];
    word_t f [NWORDS];
    logic [5:0] rot_amt [NWORDS/2];

    // Subkey addition on injection rounds, pass-through otherwise.
    always_comb begin
        for (int i = 0; i < NWORDS; i++)
            e[i] = state_in[i*WORD_W +: WORD_W]
                 + (inject ? subkey[i*WORD_W +: WORD_W] : '0);
    end

    assign rot_amt[0] = rot_lo(rot_idx);
    assign rot_amt[1] = rot_hi(rot_idx);

    for (genvar j = 0; j < NWORDS/2; j++) begin : g_mix
        tfc_mix u_mix (
            .a  (e[2*j]),
            .b  (e[2*j+1]),
            .rot(rot_amt[j]),
            .y0 (f[2*j]),
            .y1 (f[2*j+1])
        );
    end

    // Word reorder to (f0, f3, f2, f1).
    assign state_out = {f[1], f[2], f[3], f[0]};
endmodule

// File: rtl/tf256_core.sv
// Iterative 256-bit tweakable block cipher encryption core.
// Accepts start only when idle, runs NUM_RNDS rounds at one per clock, then
// adds the last subkey, optionally XORs the captured plaintext, and pulses
// done. Assumes NUM_RNDS is a multiple of 4.
module tf256_core
    import tfc_pkg::*;
#(
    parameter int NUM_RNDS = 72
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               feed_fwd,
    input  logic [255:0]       key_in,
    input  logic [127:0]       tweak_in,
    input  logic [255:0]       text_in,
    output logic [255:0]       result,
    output logic               done
);
    localparam int NUM_INJ = NUM_RNDS / 4 + 1;
    localparam int CNT_W   = $clog2(NUM_RNDS);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NUM_RNDS - 1);

    logic               busy;
    logic [CNT_W-1:0]   rnd;
    logic [BLOCK_W-1:0] state_q;
    logic [BLOCK_W-1:0] ptxt_q;
    logic               ff_q;
    logic [BLOCK_W-1:0] subkey;
    logic [BLOCK_W-1:0] round_out;
    logic [BLOCK_W-1:0] final_sum;
    logic               accept;
    logic               inject;
    logic               last;

    assign accept = start && !busy;
    assign inject = busy && (rnd[1:0] == 2'b00);
    assign last   = busy && (rnd == LAST_RND);

    tfc_key_ring #(.NUM_INJ(NUM_INJ)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (inject),
        .key_in  (key_in),
        .tweak_in(tweak_in),
        .subkey  (subkey)
    );

    tfc_round u_round (
        .state_in (state_q),
        .subkey   (subkey),
        .inject   (inject),
        .rot_idx  (rnd[2:0]),
        .state_out(round_out)
    );

    // Final subkey addition, fused onto the last round's output.
    always_comb begin
        for (int i = 0; i < NWORDS; i++)
            final_sum[i*WORD_W +: WORD_W] = round_out[i*WORD_W +: WORD_W]
                                          + subkey[i*WORD_W +: WORD_W];
    end

    // Sequencer: operand capture, round stepping, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rnd     <= '0;
            state_q <= '0;
            ptxt_q  <= '0;
            ff_q    <= 1'b0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                rnd     <= '0;
                state_q <= text_in;
                ptxt_q  <= text_in;
                ff_q    <= feed_fwd;
            end else if (busy) begin
                state_q <= round_out;
                rnd     <= rnd + 1'b1;
                if (last) begin
                    busy   <= 1'b0;
                    rnd    <= '0;
                    done   <= 1'b1;
                    result <= ff_q ? (final_sum ^ ptxt_q) : final_sum;
                end
            end
        end
    end

    // R5: done never lasts more than one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: done only follows a cycle in which a run was active
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    // R6: a start during a run does not restart the round count
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && rnd == $past(rnd) + 1'b1));
    // R8: result changes only together with a done pulse
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

// File: tb/tf256_core_bench.sv
// Self-checking bench: seeded random and directed operands, bench-side model.
module tf256_core_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         feed_fwd = 1'b0;
    logic [255:0] key_in = '0;
    logic [127:0] tweak_in = '0;
    logic [255:0] text_in = '0;
    logic [255:0] result;
    logic         done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tf256_core u_tf256_core (
        .clk(clk), .rst_n(rst_n), .start(start), .feed_fwd(feed_fwd),
        .key_in(key_in), .tweak_in(tweak_in), .text_in(text_in),
        .result(result), .done(done)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [63:0] brot(input logic [63:0] x, input int r);
        return (x << r) | (x >> (64 - r));
    endfunction

    // Bench model of the cipher, written from the requirement text.
    function automatic logic [255:0] model(input logic [255:0] k, input logic [127:0] t,
                                           input logic [255:0] p, input logic ff);
        int ra [8] = '{14, 52, 23, 5, 25, 46, 58, 32};
        int rb [8] = '{16, 57, 40, 37, 33, 12, 22, 32};
        logic [63:0] kk [5];
        logic [63:0] tt [3];
        logic [63:0] v [4];
        logic [63:0] f [4];
        logic [63:0] sk;
        logic [255:0] out;
        kk[4] = 64'h1BD11BDAA9FC1A22;
        for (int i = 0; i < 4; i++) begin
            kk[i] = k[64*i +: 64];
            kk[4] = kk[4] ^ kk[i];
            v[i] = p[64*i +: 64];
        end
        tt[0] = t[63:0];
        tt[1] = t[127:64];
        tt[2] = tt[0] ^ tt[1];
        for (int d = 0; d <= 72; d++) begin
            if (d % 4 == 0) begin
                for (int i = 0; i < 4; i++) begin
                    sk = kk[(d/4 + i) % 5];
                    if (i == 1) sk = sk + tt[(d/4) % 3];
                    if (i == 2) sk = sk + tt[(d/4 + 1) % 3];
                    if (i == 3) sk = sk + 64'(d/4);
                    v[i] = v[i] + sk;
                end
            end
            if (d == 72) break;
            f[0] = v[0] + v[1];
            f[1] = f[0] ^ brot(v[1], ra[d % 8]);
            f[2] = v[2] + v[3];
            f[3] = f[2] ^ brot(v[3], rb[d % 8]);
            v[0] = f[0]; v[1] = f[3]; v[2] = f[2]; v[3] = f[1];
        end
        for (int i = 0; i < 4; i++)
            out[64*i +: 64] = ff ? (v[i] ^ p[64*i +: 64]) : v[i];
        return out;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    // One encryption; optionally scramble inputs and re-pulse start mid-run.
    task automatic run_op(input logic [255:0] k, input logic [127:0] t,
                          input logic [255:0] p, input logic ff,
                          input logic disturb, input string req);
        logic [255:0] exp;
        int n;
        int pulses;
        exp = model(k, t, p, ff);
        @(negedge clk);
        key_in = k; tweak_in = t; text_in = p; feed_fwd = ff; start = 1'b1;
        @(negedge clk);
        n = 1;
        start = 1'b0;
        pulses = 0;
        if (disturb) begin
            key_in = rnd256(); tweak_in = rnd256()[127:0];
            text_in = rnd256(); feed_fwd = ~ff;
        end
        while (!done && n < 200) begin
            if (disturb && n == 30) start = 1'b1;
            if (disturb && n == 31) start = 1'b0;
            @(negedge clk);
            n = n + 1;
        end
        // R5: done visible on the 73rd falling edge after start
        check(n == 73, "R5 latency", 256'(n), 256'd73);
        check(result == exp, req, result, exp);
        for (int w = 0; w < 6; w++) begin
            if (done) pulses = pulses + 1;
            @(negedge clk);
        end
        // R5/R6: exactly one done pulse
        check(pulses == 1, "R5 single pulse", 256'(pulses), 256'd1);
        // R8: result held after completion
        check(result == exp, "R8 hold", result, exp);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done", 256'(done), 256'd0);
        check(result == '0, "R1 result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 after release", result, '0);

        // Directed corners (R2, R3, R4)
        run_op('0, '0, '0, 1'b0, 1'b0, "R2 zero block");
        run_op('1, '1, '1, 1'b0, 1'b0, "R3 all ones");
        run_op('0, '0, '0, 1'b1, 1'b0, "R4 zero feed-forward");
        run_op({4{64'hFFFF_FFFF_FFFF_FFFF}}, 128'h1, 256'h1, 1'b1, 1'b0, "R4 carry ff");

        // Random operands, both modes (R2, R3, R4)
        for (int i = 0; i < 12; i++)
            run_op(rnd256(), rnd256()[127:0], rnd256(), i[0], 1'b0,
                   i[0] ? "R4 random ff" : "R2 random");

        // Inputs changed and start re-pulsed mid-run (R6, R7)
        for (int i = 0; i < 4; i++)
            run_op(rnd256(), rnd256()[127:0], rnd256(), i[0], 1'b1, "R6 R7 disturbed");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule